// File: doc/BRIEF.md
# CHS Sector Address Sequencer

The sequencer turns a cylinder/head/sector position into a linear block address and walks through the sectors of a multi-sector transfer. The geometry of the attached drive is held on three inputs: cylinder count, heads per cylinder and sectors per track. It also tracks the cylinder the heads currently sit on. A command either moves the heads (seek, park, recalibrate) or starts a transfer of a number of sectors. A transfer may first move the heads to the requested cylinder.

Before each address is produced, the requested position is checked against the current cylinder and the geometry. A valid address is computed without a hardware multiplier. A single shift-add unit is used twice: once for the track number and once for the block number. The address is then presented until the consumer acknowledges it with `step`. Each step advances the position with sector-first ordering until the sector count runs out or the last cylinder is passed. Every command ends with a one-cycle `done` pulse, and the error flags remain readable until the next command is accepted.

FSM states: `ST_IDLE` (accepts a command), `ST_CHECK` (range checks), `ST_LD_TRK` / `ST_WAIT_TRK` (track = cylinder × heads + head), `ST_LD_LBA` / `ST_WAIT_LBA` (address = track × sectors + sector − 1), `ST_PRESENT` (address valid, waits for step), `ST_FINISH` (done pulse). The transitions are:
- IDLE→CHECK: a transfer with a non-zero count whose optional seek succeeded.
- IDLE→FINISH: any other command.
- CHECK→LD_TRK when the checks pass, otherwise CHECK→FINISH.
- LD_TRK→WAIT_TRK→LD_LBA→WAIT_LBA→PRESENT, each wait ending when the multiplier is idle.
- PRESENT→CHECK on a step that leaves sectors to do.
- PRESENT→FINISH on the last step or on a cylinder overflow.
- FINISH→IDLE.

Top module: `chs_sequencer`

## Requirements
- R1: A transfer (op code 0) produces `lba` = (cylinder × heads + head) × sectors_per_track + sector − 1, where sectors are numbered from 1. `addr_valid` rises on the 21st rising edge after the edge that accepted the command or the step, using the default parameters.
- R2: While `addr_valid` is high and `step` is low, `addr_valid` stays high and `lba` holds its value.
- R3: When the requested cylinder differs from the current cylinder, `err_wrong_cyl` is set, no address is produced and the command ends. This check has priority over R4 and R5.
- R4: A head number greater than or equal to the head count sets `err_cyl` (and no address is produced). This check has priority over R5. At most one error flag is set at any time.
- R5: A sector number of 0 or above sectors-per-track sets `err_sector`, and no address is produced.
- R6: On a step, the sector increments. Past the last sector it wraps to 1 and the head increments. Past the last head, the head wraps to 0 and both the requested and the current cylinder increment.
- R7: A step that would move past the last cylinder keeps the cylinder at the last one, sets `err_cyl` and ends the transfer.
- R8: Seek (op code 1) to a cylinder below the cylinder count updates `cur_cyl` and sets `seek_end`. A seek to any other cylinder sets `err_cyl` and leaves `cur_cyl` unchanged. With `cmd_autoseek` set, a transfer performs the same check and move first, without setting `seek_end`.
- R9: Park (op code 2) moves to cylinder count − 1 and sets `seek_end`. Recalibrate (op code 3) sets `cur_cyl` to 0.
- R10: Every accepted command ends with `done` high for exactly one cycle, after which `busy` is low. A transfer ends after `cmd_count` steps, and a count of 0 ends it with no address.
- R11: `cmd_valid` is ignored while `busy` is high.
- R12: After reset, `busy`, `addr_valid`, `done`, all error flags and `seek_end` are low, and `cur_cyl` is 0.
- R13: The cylinder is assembled from an 8-bit low byte (`cmd_cyl_lo`) and a 2-bit high field (`cmd_cyl_hi`, which supplies bits 9:8). The head field is 4 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| geo_cyls | input | 11 | Cylinder count of the drive |
| geo_heads | input | 5 | Heads per cylinder |
| geo_spt | input | 8 | Sectors per track |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_op | input | 2 | 0 transfer, 1 seek, 2 park, 3 recalibrate |
| cmd_cyl_lo | input | 8 | Target cylinder bits 7:0 |
| cmd_cyl_hi | input | 2 | Target cylinder bits 9:8 |
| cmd_head | input | 4 | Starting head |
| cmd_sect | input | 8 | Starting sector (1-based) |
| cmd_count | input | 8 | Number of sectors to transfer |
| cmd_autoseek | input | 1 | Transfer first moves to the target cylinder |
| step | input | 1 | Acknowledges the presented address |
| busy | output | 1 | A command is in progress |
| addr_valid | output | 1 | `lba` holds a checked address |
| lba | output | 22 | Linear block address |
| done | output | 1 | One-cycle end-of-command pulse |
| err_wrong_cyl | output | 1 | Requested cylinder is not under the heads |
| err_cyl | output | 1 | Head, seek or cylinder range error |
| err_sector | output | 1 | Sector number out of range |
| seek_end | output | 1 | Seek or park completed |
| cur_cyl | output | 10 | Cylinder the heads are on |

## Verification
The hardest state to reach is the cylinder overflow of R7. It needs a transfer that starts on the last track of the last cylinder and takes a step past the final sector. A small geometry makes this quick to set up: an autoseek to the last cylinder, the last head and the last sector is followed by a single step. The largest geometry is then used to drive the same path with the full 10-bit cylinder split across both fields. A command offered while an address is held and not yet stepped shows R11 through `cur_cyl`, which is left unchanged once the transfer ends.

// File: rtl/chs_pkg.sv
package chs_pkg;

    typedef enum logic [1:0] {
        OP_XFER  = 2'd0,
        OP_SEEK  = 2'd1,
        OP_PARK  = 2'd2,
        OP_RECAL = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        CHK_OK,
        CHK_WRONG_CYL,
        CHK_HEAD,
        CHK_SECT
    } chk_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_LD_TRK,
        ST_WAIT_TRK,
        ST_LD_LBA,
        ST_WAIT_LBA,
        ST_PRESENT,
        ST_FINISH
    } st_e;

endpackage

// File: rtl/chs_shift_mul.sv
module chs_shift_mul #(
    parameter int AW = 14,
    parameter int BW = 8,
    parameter int PW = 22
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] a,
    input  logic [BW-1:0] b,
    output logic          idle,
    output logic [PW-1:0] prod
);
    localparam int CNT_W = $clog2(BW + 1);

    logic [PW-1:0]    acc;
    logic [PW-1:0]    mcand;
    logic [BW-1:0]    mplier;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc    <= '0;
            mcand  <= '0;
            mplier <= '0;
            cnt    <= '0;
        end else if (load) begin
            acc    <= '0;
            mcand  <= PW'(a);
            mplier <= b;
            cnt    <= CNT_W'(BW);
        end else if (cnt != '0) begin
            if (mplier[0]) begin
                acc <= acc + mcand;
            end
            mcand  <= mcand << 1;
            mplier <= mplier >> 1;
            cnt    <= cnt - 1'b1;
        end
    end

    assign idle = (cnt == '0);
    assign prod = acc;

endmodule

// File: rtl/chs_range_check.sv
module chs_range_check
    import chs_pkg::*;
#(
    parameter int CYL_W  = 10,
    parameter int HEAD_W = 4,
    parameter int SECT_W = 8
) (
    input  logic [CYL_W-1:0]  req_cyl,
    input  logic [CYL_W-1:0]  cur_cyl,
    input  logic [HEAD_W-1:0] req_head,
    input  logic [SECT_W-1:0] req_sect,
    input  logic [HEAD_W:0]   geo_heads,
    input  logic [SECT_W-1:0] geo_spt,
    output chk_e              verdict
);
    always_comb begin
        if (req_cyl != cur_cyl) begin
            verdict = CHK_WRONG_CYL;
        end else if ({1'b0, req_head} >= geo_heads) begin
            verdict = CHK_HEAD;
        end else if ((req_sect == '0) || (req_sect > geo_spt)) begin
            verdict = CHK_SECT;
        end else begin
            verdict = CHK_OK;
        end
    end

endmodule

// File: rtl/chs_pos_step.sv
module chs_pos_step #(
    parameter int CYL_W  = 10,
    parameter int HEAD_W = 4,
    parameter int SECT_W = 8
) (
    input  logic [CYL_W-1:0]  cyl,
    input  logic [HEAD_W-1:0] head,
    input  logic [SECT_W-1:0] sect,
    input  logic [CYL_W:0]    geo_cyls,
    input  logic [HEAD_W:0]   geo_heads,
    input  logic [SECT_W-1:0] geo_spt,
    output logic [CYL_W-1:0]  nxt_cyl,
    output logic [HEAD_W-1:0] nxt_head,
    output logic [SECT_W-1:0] nxt_sect,
    output logic              cyl_inc,
    output logic              overflow
);
    logic [CYL_W:0]  cyl_up;
    logic [HEAD_W:0] head_up;

    assign cyl_up  = {1'b0, cyl} + 1'b1;
    assign head_up = {1'b0, head} + 1'b1;

    always_comb begin
        nxt_cyl  = cyl;
        nxt_head = head;
        nxt_sect = sect + 1'b1;
        cyl_inc  = 1'b0;
        overflow = 1'b0;
        if (sect >= geo_spt) begin
            nxt_sect = SECT_W'(1);
            if (head_up >= geo_heads) begin
                nxt_head = '0;
                if (cyl_up >= geo_cyls) begin
                    overflow = 1'b1;
                end else begin
                    nxt_cyl = cyl_up[CYL_W-1:0];
                    cyl_inc = 1'b1;
                end
            end else begin
                nxt_head = head_up[HEAD_W-1:0];
            end
        end
    end

endmodule

// File: rtl/chs_sequencer.sv
module chs_sequencer
    import chs_pkg::*;
#(
    parameter int CYL_W  = 10,
    parameter int HEAD_W = 4,
    parameter int SECT_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [CYL_W:0]                  geo_cyls,
    input  logic [HEAD_W:0]                 geo_heads,
    input  logic [SECT_W-1:0]               geo_spt,
    input  logic                            cmd_valid,
    input  logic [1:0]                      cmd_op,
    input  logic [7:0]                      cmd_cyl_lo,
    input  logic [CYL_W-9:0]                cmd_cyl_hi,
    input  logic [HEAD_W-1:0]               cmd_head,
    input  logic [SECT_W-1:0]               cmd_sect,
    input  logic [CNT_W-1:0]                cmd_count,
    input  logic                            cmd_autoseek,
    input  logic                            step,
    output logic                            busy,
    output logic                            addr_valid,
    output logic [CYL_W+HEAD_W+SECT_W-1:0]  lba,
    output logic                            done,
    output logic                            err_wrong_cyl,
    output logic                            err_cyl,
    output logic                            err_sector,
    output logic                            seek_end,
    output logic [CYL_W-1:0]                cur_cyl
);
    localparam int TRK_W = CYL_W + HEAD_W;
    localparam int LBA_W = TRK_W + SECT_W;
    localparam int MB_W  = (HEAD_W + 1 > SECT_W) ? HEAD_W + 1 : SECT_W;

    st_e               state, nxt_state;
    logic [CYL_W-1:0]  req_cyl;
    logic [HEAD_W-1:0] req_head;
    logic [SECT_W-1:0] req_sect;
    logic [CNT_W-1:0]  remain;
    logic [TRK_W-1:0]  trk;
    logic [LBA_W-1:0]  lba_q;

    logic [CYL_W-1:0]  tgt_cyl;
    logic              tgt_ok;
    logic [CYL_W-1:0]  park_cyl;
    chk_e              verdict;

    logic [CYL_W-1:0]  st_cyl;
    logic [HEAD_W-1:0] st_head;
    logic [SECT_W-1:0] st_sect;
    logic              st_cyl_inc;
    logic              st_ovf;

    logic              mul_load;
    logic [TRK_W-1:0]  mul_a;
    logic [MB_W-1:0]   mul_b;
    logic              mul_idle;
    logic [LBA_W-1:0]  mul_prod;

    assign tgt_cyl  = {cmd_cyl_hi, cmd_cyl_lo};
    assign tgt_ok   = ({1'b0, tgt_cyl} < geo_cyls);
    assign park_cyl = CYL_W'(geo_cyls - 1'b1);

    chs_range_check #(
        .CYL_W (CYL_W),
        .HEAD_W(HEAD_W),
        .SECT_W(SECT_W)
    ) u_check (
        .req_cyl  (req_cyl),
        .cur_cyl  (cur_cyl),
        .req_head (req_head),
        .req_sect (req_sect),
        .geo_heads(geo_heads),
        .geo_spt  (geo_spt),
        .verdict  (verdict)
    );

    chs_pos_step #(
        .CYL_W (CYL_W),
        .HEAD_W(HEAD_W),
        .SECT_W(SECT_W)
    ) u_step (
        .cyl      (req_cyl),
        .head     (req_head),
        .sect     (req_sect),
        .geo_cyls (geo_cyls),
        .geo_heads(geo_heads),
        .geo_spt  (geo_spt),
        .nxt_cyl  (st_cyl),
        .nxt_head (st_head),
        .nxt_sect (st_sect),
        .cyl_inc  (st_cyl_inc),
        .overflow (st_ovf)
    );

    assign mul_load = (state == ST_LD_TRK) || (state == ST_LD_LBA);
    assign mul_a    = (state == ST_LD_TRK) ? TRK_W'(req_cyl) : trk;
    assign mul_b    = (state == ST_LD_TRK) ? MB_W'(geo_heads) : MB_W'(geo_spt);

    chs_shift_mul #(
        .AW(TRK_W),
        .BW(MB_W),
        .PW(LBA_W)
    ) u_mul (
        .clk  (clk),
        .rst_n(rst_n),
        .load (mul_load),
        .a    (mul_a),
        .b    (mul_b),
        .idle (mul_idle),
        .prod (mul_prod)
    );

    // Next-state decision
    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if ((op_e'(cmd_op) == OP_XFER) && (cmd_count != '0) &&
                        !(cmd_autoseek && !tgt_ok)) begin
                        nxt_state = ST_CHECK;
                    end else begin
                        nxt_state = ST_FINISH;
                    end
                end
            end
            ST_CHECK:    nxt_state = (verdict == CHK_OK) ? ST_LD_TRK : ST_FINISH;
            ST_LD_TRK:   nxt_state = ST_WAIT_TRK;
            ST_WAIT_TRK: nxt_state = mul_idle ? ST_LD_LBA : ST_WAIT_TRK;
            ST_LD_LBA:   nxt_state = ST_WAIT_LBA;
            ST_WAIT_LBA: nxt_state = mul_idle ? ST_PRESENT : ST_WAIT_LBA;
            ST_PRESENT: begin
                if (step) begin
                    if ((remain == CNT_W'(1)) || st_ovf) begin
                        nxt_state = ST_FINISH;
                    end else begin
                        nxt_state = ST_CHECK;
                    end
                end
            end
            ST_FINISH:   nxt_state = ST_IDLE;
            default:     nxt_state = ST_IDLE;
        endcase
    end

    // State register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            cur_cyl       <= '0;
            req_cyl       <= '0;
            req_head      <= '0;
            req_sect      <= '0;
            remain        <= '0;
            trk           <= '0;
            lba_q         <= '0;
            err_wrong_cyl <= 1'b0;
            err_cyl       <= 1'b0;
            err_sector    <= 1'b0;
            seek_end      <= 1'b0;
        end else begin
            state <= nxt_state;
            unique case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        err_wrong_cyl <= 1'b0;
                        err_cyl       <= 1'b0;
                        err_sector    <= 1'b0;
                        seek_end      <= 1'b0;
                        unique case (op_e'(cmd_op))
                            OP_SEEK: begin
                                if (tgt_ok) begin
                                    cur_cyl  <= tgt_cyl;
                                    seek_end <= 1'b1;
                                end else begin
                                    err_cyl <= 1'b1;
                                end
                            end
                            OP_PARK: begin
                                if (geo_cyls != '0) begin
                                    cur_cyl  <= park_cyl;
                                    seek_end <= 1'b1;
                                end else begin
                                    err_cyl <= 1'b1;
                                end
                            end
                            OP_RECAL: cur_cyl <= '0;
                            OP_XFER: begin
                                req_cyl  <= tgt_cyl;
                                req_head <= cmd_head;
                                req_sect <= cmd_sect;
                                remain   <= cmd_count;
                                if (cmd_autoseek) begin
                                    if (tgt_ok) begin
                                        cur_cyl <= tgt_cyl;
                                    end else begin
                                        err_cyl <= 1'b1;
                                    end
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                ST_CHECK: begin
                    unique case (verdict)
                        CHK_WRONG_CYL: err_wrong_cyl <= 1'b1;
                        CHK_HEAD:      err_cyl       <= 1'b1;
                        CHK_SECT:      err_sector    <= 1'b1;
                        default:       ;
                    endcase
                end
                ST_WAIT_TRK: begin
                    if (mul_idle) begin
                        trk <= TRK_W'(mul_prod) + TRK_W'(req_head);
                    end
                end
                ST_WAIT_LBA: begin
                    if (mul_idle) begin
                        lba_q <= mul_prod + LBA_W'(req_sect) - LBA_W'(1);
                    end
                end
                ST_PRESENT: begin
                    if (step && (remain != CNT_W'(1))) begin
                        remain <= remain - 1'b1;
                        if (st_ovf) begin
                            err_cyl <= 1'b1;
                        end else begin
                            req_cyl  <= st_cyl;
                            req_head <= st_head;
                            req_sect <= st_sect;
                            if (st_cyl_inc) begin
                                cur_cyl <= st_cyl;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs decoded from the state
    always_comb begin
        busy       = (state != ST_IDLE);
        addr_valid = (state == ST_PRESENT);
        done       = (state == ST_FINISH);
        lba        = lba_q;
    end

endmodule

// File: rtl/chs_sequencer_chk.sv
module chs_sequencer_chk #(
    parameter int CYL_W = 10,
    parameter int LBA_W = 22
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CYL_W:0]   geo_cyls,
    input logic             cmd_valid,
    input logic [1:0]       cmd_op,
    input logic             step,
    input logic             busy,
    input logic             addr_valid,
    input logic [LBA_W-1:0] lba,
    input logic             done,
    input logic             err_wrong_cyl,
    input logic             err_cyl,
    input logic             err_sector,
    input logic             seek_end,
    input logic [CYL_W-1:0] cur_cyl
);
    assert_hold_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && !step |=> addr_valid && $stable(lba));

    assert_clean_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> !err_wrong_cyl && !err_cyl && !err_sector);

    assert_single_error_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_wrong_cyl, err_cyl, err_sector}));

    assert_seek_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        seek_end |-> ({1'b0, cur_cyl} < geo_cyls));

    assert_recal_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && cmd_valid && (cmd_op == 2'd3) |=> cur_cyl == '0);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    assert_ignore_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && cmd_valid && !step |=> addr_valid && $stable(cur_cyl));

endmodule

bind chs_sequencer chs_sequencer_chk #(
    .CYL_W(CYL_W),
    .LBA_W(CYL_W + HEAD_W + SECT_W)
) u_chs_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .geo_cyls     (geo_cyls),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .step         (step),
    .busy         (busy),
    .addr_valid   (addr_valid),
    .lba          (lba),
    .done         (done),
    .err_wrong_cyl(err_wrong_cyl),
    .err_cyl      (err_cyl),
    .err_sector   (err_sector),
    .seek_end     (seek_end),
    .cur_cyl      (cur_cyl)
);

// File: tb/test_chs_sequencer.sv
module test_chs_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] geo_cyls = 11'd10;
    logic [4:0]  geo_heads = 5'd3;
    logic [7:0]  geo_spt = 8'd5;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [7:0]  cmd_cyl_lo = 8'd0;
    logic [1:0]  cmd_cyl_hi = 2'd0;
    logic [3:0]  cmd_head = 4'd0;
    logic [7:0]  cmd_sect = 8'd0;
    logic [7:0]  cmd_count = 8'd0;
    logic        cmd_autoseek = 1'b0;
    logic        step = 1'b0;
    logic        busy, addr_valid, done;
    logic [21:0] lba;
    logic        err_wrong_cyl, err_cyl, err_sector, seek_end;
    logic [9:0]  cur_cyl;

    chs_sequencer i_chs_sequencer (
        .clk(clk), .rst_n(rst_n), .geo_cyls(geo_cyls), .geo_heads(geo_heads),
        .geo_spt(geo_spt), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_cyl_lo(cmd_cyl_lo), .cmd_cyl_hi(cmd_cyl_hi), .cmd_head(cmd_head),
        .cmd_sect(cmd_sect), .cmd_count(cmd_count), .cmd_autoseek(cmd_autoseek),
        .step(step), .busy(busy), .addr_valid(addr_valid), .lba(lba), .done(done),
        .err_wrong_cyl(err_wrong_cyl), .err_cyl(err_cyl), .err_sector(err_sector),
        .seek_end(seek_end), .cur_cyl(cur_cyl)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    int got[$];

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: phase 0 idle, 1 computing, 2 presenting, 3 finishing
    int m_phase, m_cd, m_cur, m_c, m_h, m_s, m_cnt, m_lba;
    bit m_we, m_ec, m_es, m_se;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_cur = 0; m_we = 0; m_ec = 0; m_es = 0; m_se = 0;
            m_cd = 0; m_cnt = 0;
        end else begin
            case (m_phase)
                0: if (cmd_valid) begin
                    int tgt;
                    tgt = cmd_cyl_hi * 256 + cmd_cyl_lo;
                    m_we = 0; m_ec = 0; m_es = 0; m_se = 0;
                    m_phase = 3;
                    if (cmd_op == 2'd1) begin
                        if (tgt < geo_cyls) begin m_cur = tgt; m_se = 1; end
                        else m_ec = 1;
                    end else if (cmd_op == 2'd2) begin
                        if (geo_cyls > 0) begin m_cur = geo_cyls - 1; m_se = 1; end
                        else m_ec = 1;
                    end else if (cmd_op == 2'd3) begin
                        m_cur = 0;
                    end else begin
                        m_c = tgt; m_h = cmd_head; m_s = cmd_sect; m_cnt = cmd_count;
                        if (cmd_autoseek && tgt >= geo_cyls) m_ec = 1;
                        else begin
                            if (cmd_autoseek) m_cur = tgt;
                            if (m_cnt != 0) begin m_phase = 1; m_cd = LAT; end
                        end
                    end
                end
                1: begin
                    m_cd--;
                    if (m_cd == LAT - 1) begin
                        if (m_c != m_cur) begin m_we = 1; m_phase = 3; end
                        else if (m_h >= geo_heads) begin m_ec = 1; m_phase = 3; end
                        else if (m_s == 0 || m_s > geo_spt) begin m_es = 1; m_phase = 3; end
                    end
                    if (m_phase == 1 && m_cd == 0) begin
                        m_lba = (m_c * geo_heads + m_h) * geo_spt + m_s - 1;
                        m_phase = 2;
                    end
                end
                2: if (step) begin
                    if (m_cnt == 1) m_phase = 3;
                    else begin
                        m_cnt--;
                        m_s++;
                        if (m_s > geo_spt) begin
                            m_s = 1; m_h++;
                            if (m_h >= geo_heads) begin
                                m_h = 0;
                                if (m_c + 1 >= geo_cyls) begin
                                    m_ec = 1; m_phase = 3; m_h = 0;
                                end else begin
                                    m_c++; m_cur = m_c;
                                end
                            end
                        end
                        if (m_phase == 2) begin m_phase = 1; m_cd = LAT; end
                    end
                end
                default: m_phase = 0;
            endcase
        end
    end

    // Compare against the reference on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R10 busy", busy, m_phase != 0);
            chk("R10 done", done, m_phase == 3);
            chk("R1 addr_valid", addr_valid, m_phase == 2);
            if (m_phase == 2) chk("R1 lba", lba, m_lba);
            chk("R3 err_wrong_cyl", err_wrong_cyl, m_we);
            chk("R4 err_cyl", err_cyl, m_ec);
            chk("R5 err_sector", err_sector, m_es);
            chk("R8 seek_end", seek_end, m_se);
            chk("R6 cur_cyl", cur_cyl, m_cur);
        end
    end

    task automatic run_cmd(input int op, input int cyl, input int head, input int sect,
                           input int cnt, input bit as, input int hold, input bit poke);
        got.delete();
        @(negedge clk);
        cmd_op = 2'(op); cmd_cyl_lo = 8'(cyl); cmd_cyl_hi = 2'(cyl >> 8);
        cmd_head = 4'(head); cmd_sect = 8'(sect); cmd_count = 8'(cnt);
        cmd_autoseek = as; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done) begin
            if (addr_valid) begin
                got.push_back(int'(lba));
                if (poke) begin
                    cmd_op = 2'd3; cmd_valid = 1'b1;
                    @(negedge clk);
                    cmd_valid = 1'b0;
                end
                repeat (hold) @(negedge clk);
                step = 1'b1;
                @(negedge clk);
                step = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        @(negedge clk);
    endtask

    task automatic chk_list(input string tag, input int exp[$]);
        chk({tag, " count"}, got.size(), exp.size());
        foreach (exp[i]) begin
            if (i < got.size()) chk(tag, got[i], exp[i]);
        end
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 busy", busy, 0);
        chk("R12 addr_valid", addr_valid, 0);
        chk("R12 done", done, 0);
        chk("R12 flags", {err_wrong_cyl, err_cyl, err_sector, seek_end}, 0);
        chk("R12 cur_cyl", cur_cyl, 0);
        rst_n = 1'b1;

        run_cmd(3, 0, 0, 0, 0, 0, 0, 0);
        chk("R9 recal", cur_cyl, 0);
        run_cmd(1, 4, 0, 0, 0, 0, 0, 0);
        chk("R8 seek cyl", cur_cyl, 4);
        chk("R8 seek_end", seek_end, 1);

        // R1/R6 head wrap within a cylinder
        run_cmd(0, 4, 1, 2, 6, 0, 0, 0);
        chk_list("R1 R6 lba seq", '{66, 67, 68, 69, 70, 71});

        // R6 cylinder wrap; R2 hold; R11 command while busy ignored
        run_cmd(0, 4, 2, 4, 4, 0, 3, 1);
        chk_list("R6 R2 lba seq", '{73, 74, 75, 76});
        chk("R11 cur_cyl after poke", cur_cyl, 5);

        run_cmd(0, 3, 0, 1, 1, 0, 0, 0);
        chk("R3 wrong cyl", err_wrong_cyl, 1);
        chk("R3 no address", got.size(), 0);

        // R7 overflow clamp
        run_cmd(0, 9, 2, 5, 3, 1, 0, 0);
        chk_list("R7 last lba", '{149});
        chk("R7 err_cyl", err_cyl, 1);
        chk("R7 clamp", cur_cyl, 9);

        run_cmd(0, 0, 3, 1, 1, 1, 0, 0);
        chk("R4 head range", err_cyl, 1);
        chk("R8 autoseek no seek_end", seek_end, 0);
        chk("R8 autoseek cyl", cur_cyl, 0);

        run_cmd(0, 2, 3, 9, 1, 0, 0, 0);
        chk("R3 priority wrong", err_wrong_cyl, 1);
        chk("R4 priority others", {err_cyl, err_sector}, 0);

        run_cmd(0, 1, 0, 6, 1, 1, 0, 0);
        chk("R5 sector high", err_sector, 1);
        run_cmd(0, 1, 0, 0, 1, 1, 0, 0);
        chk("R5 sector zero", err_sector, 1);

        run_cmd(1, 10, 0, 0, 0, 0, 0, 0);
        chk("R8 seek fail", err_cyl, 1);
        chk("R8 seek fail cyl", cur_cyl, 1);

        run_cmd(2, 0, 0, 0, 0, 0, 0, 0);
        chk("R9 park", cur_cyl, 9);
        chk("R9 park seek_end", seek_end, 1);

        run_cmd(0, 3, 0, 1, 0, 1, 0, 0);
        chk("R10 zero count", got.size(), 0);
        chk("R10 zero count cyl", cur_cyl, 3);

        // Largest geometry: R13 cylinder field split
        @(negedge clk);
        rst_n = 1'b0;
        geo_cyls = 11'd1024; geo_heads = 5'd16; geo_spt = 8'd255;
        @(negedge clk);
        rst_n = 1'b1;
        run_cmd(0, 600, 7, 100, 1, 1, 0, 0);
        chk_list("R13 mid lba", '{2449884});
        chk("R13 cyl 600", cur_cyl, 600);
        run_cmd(0, 1023, 15, 255, 2, 1, 1, 0);
        chk_list("R13 top lba", '{4177919});
        chk("R7 top overflow", err_cyl, 1);
        chk("R7 top clamp", cur_cyl, 1023);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule